// File: doc/BRIEF.md
# Synchronous Master Serial Transmitter

This block drives a bit clock line and a data line as the bus master of a half-duplex synchronous serial link. A host writes words into a holding register. When transmission is enabled, each word moves into a shift register and goes out least significant bit first. An optional ninth bit, taken from a separate single-bit register, can be appended. A programmable divider sets the bit rate, and one input selects whether the clock line rests high or low.

The holding register is double-buffered against the shift register. The host can write the next word while the current one is still shifting, and the two words then go out with no idle clock periods between them. The block reports two conditions. A holding-empty flag can raise an interrupt when its enable is set. A shift-empty status is meant to be polled. While a word is in flight, a receive-inhibit output keeps the receiver that shares the link quiet.

The controller is a three-state machine:
- IDLE: no word is in the shift register.
- LOAD: a single cycle that transfers the first word into the shift register.
- SHIFT: bits are being serialized.

The state transitions are:
- IDLE to LOAD: the holding register is full and transmission is enabled.
- LOAD to SHIFT: always, while transmission stays enabled.
- SHIFT to SHIFT, with a reload: the last bit ends and the holding register is full.
- SHIFT to IDLE: the last bit ends and the holding register is empty.
- LOAD or SHIFT to IDLE: the transmit enable drops, which aborts the word.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset:
  - `sclk` is at the idle level.
  - `sdata` is 0.
  - `hold_empty` is 1.
  - `shift_empty` is 1.
  - `rx_inhibit` is 0.
- R2: Whenever `shift_empty` is 1, `sclk` equals `clk_idle_high`: 1 means the clock rests high, 0 means it rests low.
- R3: Word timing and bit order:
  - Bits leave least significant first.
  - Each bit lasts 4*(`div_n`+1) cycles.
  - `sclk` is at the non-idle level for the first half of each bit.
  - `sdata` changes only on the cycle in which `sclk` leaves idle, so it is stable when `sclk` returns to idle.
- R4: With `nine_bit_en` = 1, a word is 9 bits long. Bit 8 is the value of the ninth-bit register at the moment the word was written. That register is loaded by `ninth_wr` and `ninth_val`. With `nine_bit_en` = 0, a word is 8 bits long.
- R5: `hold_empty` behaves as follows:
  - It falls in the cycle after a `wr_stb`.
  - It rises in the cycle after the word moves into the shift register.
  - Nothing but a write clears it.
- R6: `irq` is high only when `hold_empty` = 1 and `irq_en` = 1.
- R7: If the holding register is full when the last bit of a word ends, the next word starts on the very next bit period. No idle clock time falls between the two words.
- R8: While `tx_en` = 0, a written word stays in the holding register:
  - no clock pulses are produced;
  - `hold_empty` stays 0.
- R9: The first word is launched as follows:
  - Write sampled at edge E0.
  - LOAD state after E1: `shift_empty` = 0 and `sclk` is still idle.
  - After E2: `sclk` leaves idle, and `hold_empty` = 1.
- R10: Dropping `tx_en` during a word aborts it. After the next clock edge, `sclk` is idle and `shift_empty` = 1.
- R11: `rx_inhibit` is high exactly when `shift_empty` is low.
- R12: `shift_empty` is 0 from the LOAD cycle until the last bit ends, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable; clearing it aborts a word |
| clk_idle_high | input | 1 | Idle level of `sclk` |
| nine_bit_en | input | 1 | Selects 9-bit words |
| ninth_wr | input | 1 | Load strobe for the ninth-bit register |
| ninth_val | input | 1 | Value for the ninth-bit register |
| div_n | input | 16 | Divider value N; the bit period is 4*(N+1) cycles |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Word to transmit |
| irq_en | input | 1 | Interrupt enable for the holding-empty flag |
| sclk | output | 1 | Bit clock line |
| sdata | output | 1 | Serial data line |
| hold_empty | output | 1 | Holding register empty flag |
| shift_empty | output | 1 | Shift register empty status |
| rx_inhibit | output | 1 | High while transmitting |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: DATA_W = 8 and DIV_W = 16. At run time it uses divider values 0 to 3, so every bit lasts between 4 and 16 cycles. That keeps whole 8-bit and 9-bit words, both clock polarities, a back-to-back pair and an abort part-way through a word within a few hundred cycles. Divider value 0 gives one-cycle quarter phases. This makes a gap of even a single cycle between two words, or a data change in the wrong cycle, show up directly in the measured edge intervals.

// File: rtl/sst_pkg.sv
package sst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2
    } sst_state_e;
endpackage

// File: rtl/sst_divider.sv
module sst_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div_n);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == div_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sst_holdreg.sv
module sst_holdreg #(
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic            ninth_wr,
    input  logic            ninth_val,
    input  logic            take,
    output logic [DATA_W:0] word,
    output logic            empty
);
    logic ninth_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ninth_q <= 1'b0;
        end else if (ninth_wr) begin
            ninth_q <= ninth_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word  <= '0;
            empty <= 1'b1;
        end else if (wr_stb) begin
            word  <= {ninth_q, wr_data};
            empty <= 1'b0;
        end else if (take) begin
            empty <= 1'b1;
        end
    end
endmodule

// File: rtl/sst_fsm.sv
module sst_fsm
    import sst_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_en,
    input  logic            nine_bit_en,
    input  logic            hold_empty,
    input  logic [DATA_W:0] hold_word,
    input  logic            tick,
    output logic            take,
    output logic            run,
    output logic            clk_active,
    output logic            sdata,
    output logic            busy
);
    localparam int FRAME_W = DATA_W + 1;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST8 = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST9 = CNT_W'(FRAME_W - 1);

    sst_state_e           state_q, state_d;
    logic [1:0]           quarter_q;
    logic [CNT_W-1:0]     bitcnt_q;
    logic [FRAME_W-1:0]   shreg_q;
    logic                 last_bit;
    logic                 bit_end;

    assign last_bit = (bitcnt_q == (nine_bit_en ? LAST9 : LAST8));
    assign bit_end  = (state_q == ST_SHIFT) && tick && (quarter_q == 2'd3);

    // next-state logic
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_en && !hold_empty) state_d = ST_LOAD;
            end
            ST_LOAD: begin
                if (!tx_en) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_SHIFT;
                    take    = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (!tx_en) begin
                    state_d = ST_IDLE;
                end else if (bit_end && last_bit) begin
                    if (hold_empty) begin
                        state_d = ST_IDLE;
                    end else begin
                        take = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // shift datapath
    always_ff @(posedge clk) begin
        if (!rst_n || state_d == ST_IDLE) begin
            shreg_q   <= '0;
            bitcnt_q  <= '0;
            quarter_q <= 2'd0;
        end else if (take) begin
            shreg_q   <= nine_bit_en ? hold_word
                                     : {1'b0, hold_word[DATA_W-1:0]};
            bitcnt_q  <= '0;
            quarter_q <= 2'd0;
        end else if (state_q == ST_SHIFT && tick) begin
            quarter_q <= quarter_q + 2'd1;
            if (quarter_q == 2'd3) begin
                shreg_q  <= {1'b0, shreg_q[FRAME_W-1:1]};
                bitcnt_q <= bitcnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        run        = (state_q == ST_SHIFT) && tx_en;
        clk_active = (state_q == ST_SHIFT) && !quarter_q[1];
        sdata      = (state_q == ST_SHIFT) ? shreg_q[0] : 1'b0;
        busy       = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              clk_idle_high,
    input  logic              nine_bit_en,
    input  logic              ninth_wr,
    input  logic              ninth_val,
    input  logic [DIV_W-1:0]  div_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_en,
    output logic              sclk,
    output logic              sdata,
    output logic              hold_empty,
    output logic              shift_empty,
    output logic              rx_inhibit,
    output logic              irq
);
    logic            tick;
    logic            run;
    logic            take;
    logic            clk_active;
    logic            busy;
    logic [DATA_W:0] hold_word;

    sst_divider #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div_n (div_n),
        .tick  (tick)
    );

    sst_holdreg #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .ninth_wr  (ninth_wr),
        .ninth_val (ninth_val),
        .take      (take),
        .word      (hold_word),
        .empty     (hold_empty)
    );

    sst_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .nine_bit_en (nine_bit_en),
        .hold_empty  (hold_empty),
        .hold_word   (hold_word),
        .tick        (tick),
        .take        (take),
        .run         (run),
        .clk_active  (clk_active),
        .sdata       (sdata),
        .busy        (busy)
    );

    assign sclk        = clk_idle_high ^ clk_active;
    assign shift_empty = !busy;
    assign rx_inhibit  = busy;
    assign irq         = hold_empty && irq_en;
endmodule

// File: rtl/sync_ser_tx_chk.sv
module sync_ser_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic clk_idle_high,
    input logic wr_stb,
    input logic sclk,
    input logic sdata,
    input logic hold_empty,
    input logic shift_empty,
    input logic rx_inhibit,
    input logic irq
);
    // R2
    a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> (sclk == clk_idle_high));

    // R5
    a_r5_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !hold_empty);

    // R5
    a_r5_only_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_empty) |-> $past(wr_stb));

    // R5
    a_r5_rise_on_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_empty) |-> !shift_empty);

    // R6
    a_r6_irq_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> hold_empty);

    // R10
    a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> shift_empty);

    // R11
    a_r11_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        rx_inhibit != shift_empty);

    // R3
    a_r3_data_on_leave_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sdata) && !shift_empty && !$past(shift_empty))
            |-> ((sclk != clk_idle_high) && !$stable(sclk)));
endmodule

bind sync_ser_tx sync_ser_tx_chk u_chk (.*);

// File: tb/sync_ser_tx_bench.sv
module sync_ser_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 5;
    // {div[15:0], idle_high, nine, ninth, data[7:0]}
    localparam logic [26:0] VEC [NV] = '{
        {16'd0, 1'b0, 1'b0, 1'b0, 8'hA5},
        {16'd1, 1'b1, 1'b0, 1'b0, 8'h3C},
        {16'd3, 1'b0, 1'b1, 1'b1, 8'h81},
        {16'd0, 1'b1, 1'b1, 1'b0, 8'hFF},
        {16'd2, 1'b0, 1'b0, 1'b0, 8'h01}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0;
    logic        clk_idle_high = 1'b0;
    logic        nine_bit_en = 1'b0;
    logic        ninth_wr = 1'b0;
    logic        ninth_val = 1'b0;
    logic [15:0] div_n = 16'd0;
    logic        wr_stb = 1'b0;
    logic [7:0]  wr_data = 8'd0;
    logic        irq_en = 1'b0;
    logic        sclk, sdata, hold_empty, shift_empty, rx_inhibit, irq;

    int checks = 0;
    int fails = 0;

    sync_ser_tx u_sync_ser_tx (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .clk_idle_high(clk_idle_high),
        .nine_bit_en(nine_bit_en), .ninth_wr(ninth_wr), .ninth_val(ninth_val),
        .div_n(div_n), .wr_stb(wr_stb), .wr_data(wr_data), .irq_en(irq_en),
        .sclk(sclk), .sdata(sdata), .hold_empty(hold_empty),
        .shift_empty(shift_empty), .rx_inhibit(rx_inhibit), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // line monitor: records leave-idle times and data at return-to-idle
    logic cap_bit [0:511];
    int   act_t   [0:511];
    int   cap_n = 0;
    int   act_n = 0;
    int   cyc = 0;
    logic prev_sclk = 1'b0;
    logic prev_inh = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rx_inhibit && prev_sclk == clk_idle_high && sclk != clk_idle_high
            && act_n < 512) begin
            act_t[act_n] = cyc;
            act_n = act_n + 1;
        end
        if (prev_inh && prev_sclk != clk_idle_high && sclk == clk_idle_high
            && cap_n < 512) begin
            cap_bit[cap_n] = sdata;
            cap_n = cap_n + 1;
        end
        prev_sclk = sclk;
        prev_inh  = rx_inhibit;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_cfg(input logic [15:0] d, input logic pol, input logic nine);
        @(posedge clk); #1;
        div_n = d; clk_idle_high = pol; nine_bit_en = nine;
    endtask

    task automatic load_ninth(input logic v);
        @(posedge clk); #1;
        ninth_wr = 1'b1; ninth_val = v;
        @(posedge clk); #1;
        ninth_wr = 1'b0;
    endtask

    task automatic write_word(input logic [7:0] d);
        @(posedge clk); #1;
        wr_stb = 1'b1; wr_data = d;
        @(posedge clk); #1;
        wr_stb = 1'b0;
    endtask

    task automatic wait_done();
        repeat (3) @(negedge clk);
        while (!shift_empty) @(negedge clk);
        @(negedge clk);
    endtask

    // checks bits and spacing of n bits captured from index cb / ab
    task automatic check_stream(input int cb, input int ab, input int n,
                                input logic [17:0] exp_bits, input int period,
                                input string req_bits, input string req_gap);
        int bad_bit = -1;
        int bad_gap = -1;
        chk(cap_n - cb == n, req_bits, cap_n - cb, n);
        for (int k = 0; k < n; k++)
            if (bad_bit < 0 && cap_bit[cb + k] !== exp_bits[k]) bad_bit = k;
        chk(bad_bit < 0, req_bits, bad_bit, -1);
        for (int k = 0; k + 1 < n; k++)
            if (bad_gap < 0 && act_t[ab + k + 1] - act_t[ab + k] != period) bad_gap = k;
        chk(bad_gap < 0, req_gap,
            bad_gap < 0 ? period : act_t[ab + bad_gap + 1] - act_t[ab + bad_gap], period);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(sclk == 1'b0, "R1 sclk", sclk, 0);
        chk(sdata == 1'b0, "R1 sdata", sdata, 0);
        chk(hold_empty && shift_empty, "R1 empties", {hold_empty, shift_empty}, 3);
        chk(!rx_inhibit && !irq, "R1 inhibit/irq", {rx_inhibit, irq}, 0);

        tx_en = 1'b1;
        // table walk: R3 R4 R2 R12
        for (int i = 0; i < NV; i++) begin
            logic [26:0] v;
            logic [17:0] eb;
            int nb, cb, ab;
            v  = VEC[i];
            nb = v[9] ? 9 : 8;
            eb = '0;
            eb[7:0] = v[7:0];
            eb[8]   = v[8];
            drive_cfg(v[26:11], v[10], v[9]);
            load_ninth(v[8]);
            cb = cap_n; ab = act_n;
            write_word(v[7:0]);
            wait_done();
            check_stream(cb, ab, nb, eb, 4 * (int'(v[26:11]) + 1),
                         "R3/R4 word bits", "R3 bit period");
            chk(sclk == v[10], "R2 idle level", sclk, v[10]);
            chk(shift_empty && !rx_inhibit, "R12/R11 done", {shift_empty, rx_inhibit}, 2);
        end

        // R9 launch timing
        drive_cfg(16'd1, 1'b0, 1'b0);
        write_word(8'h5A);
        @(negedge clk);
        chk(shift_empty && !hold_empty, "R9 after E0", {shift_empty, hold_empty}, 2);
        @(negedge clk);
        chk(!shift_empty && sclk == 1'b0, "R9 LOAD cycle", {shift_empty, sclk}, 0);
        chk(rx_inhibit, "R11 inhibit in LOAD", rx_inhibit, 1);
        @(negedge clk);
        chk(sclk == 1'b1 && hold_empty, "R9 first edge", {sclk, hold_empty}, 3);
        wait_done();

        // R7 back to back with R6 irq
        begin
            int cb, ab;
            drive_cfg(16'd0, 1'b0, 1'b0);
            irq_en = 1'b1;
            @(negedge clk);
            chk(irq, "R6 irq when empty", irq, 1);
            cb = cap_n; ab = act_n;
            write_word(8'hC3);
            @(negedge clk);
            chk(!irq, "R6 irq cleared by write", irq, 0);
            while (!hold_empty) @(negedge clk);
            write_word(8'h96);
            wait_done();
            check_stream(cb, ab, 16, {2'b00, 8'h96, 8'hC3}, 4,
                         "R7 pair bits", "R7 no gap");
            irq_en = 1'b0;
            @(negedge clk);
            chk(!irq, "R6 irq masked", irq, 0);
        end

        // R8 transmit enable gating
        begin
            int ab;
            drive_cfg(16'd0, 1'b1, 1'b0);
            tx_en = 1'b0;
            ab = act_n;
            write_word(8'h77);
            repeat (30) @(negedge clk);
            chk(act_n == ab && sclk == 1'b1, "R8 no clocks", act_n - ab, 0);
            chk(!hold_empty && shift_empty, "R8 word held", {hold_empty, shift_empty}, 1);
            @(posedge clk); #1 tx_en = 1'b1;
            wait_done();
            chk(act_n - ab == 8 && hold_empty, "R8 starts on enable", act_n - ab, 8);
        end

        // R10 abort
        drive_cfg(16'd3, 1'b0, 1'b0);
        write_word(8'hF0);
        repeat (20) @(negedge clk);
        chk(!shift_empty, "R12 busy mid-word", shift_empty, 0);
        @(posedge clk); #1 tx_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(shift_empty && sclk == 1'b0 && !rx_inhibit, "R10 abort",
            {shift_empty, sclk, rx_inhibit}, 4);
        chk(sdata == 1'b0, "R10 data idle", sdata, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule